// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block holds a small byte-addressed storage array that behaves like NOR flash, and carries out single-byte program requests and region erase requests against it. A program request can only clear bits: the stored byte becomes the old contents ANDed with the new byte. A build option makes programming overwrite the byte outright, so the array can stand in for byte-rewritable memory. An erase fills a power-of-two region with 0xFF. The region can be a small block, a medium block, one sector or the whole array. Its start is the request address rounded down to the region length. The erase walks the region one byte per clock while `busy` is high.

Each request carries its operation code, address, data byte and the current state of the write-enable latch. Misuse is recorded in sticky flags, which only reset clears. An erase while writes are disabled is dropped. A program while writes are disabled is still performed. Asking for an erase size the part does not advertise is flagged, but the erase still runs. A program that tries to turn a 0 bit into a 1 is flagged. A combinational read port shows the array contents at any address.

Top module: `flash_pe_engine`

## Requirements
- R1: During and after reset, every byte reads 0xFF, `busy` is 0 and `err_prot`, `err_size` and `err_zero` are 0.
- R2: With REWRITE_ONES=0, an accepted program (op code 0) leaves the addressed byte equal to old AND `req_data`.
- R3: With REWRITE_ONES=1, an accepted program leaves the addressed byte equal to `req_data`.
- R4: An accepted erase with `wel`=1 sets every byte in its region to 0xFF. The op codes are 1 for SMALL_BYTES, 2 for MID_BYTES, 3 for SECT_BYTES and 4 for the whole array. The region starts at `req_addr` rounded down to a multiple of the region length. Bytes outside the region keep their values.
- R5: After the accepting clock edge, `busy` is high for exactly as many cycles as the erase region has bytes.
- R6: While `busy` is high, `req_valid` is ignored: the array and all flags are unaffected.
- R7: An erase request with `wel`=0 is dropped. `busy` stays low, the array is unchanged and `err_prot` is set.
- R8: A program request with `wel`=0 still updates the byte and sets `err_prot`.
- R9: An erase with op code 1 when CAP_SMALL=0, or op code 2 when CAP_MID=0, sets `err_size`. With `wel`=1 the erase is still carried out.
- R10: A program whose data has a 1 where the stored byte has a 0 sets `err_zero`, whatever REWRITE_ONES is.
- R11: `err_prot`, `err_size` and `err_zero` stay set until reset.
- R12: Op codes 5 to 7 are ignored: no array change, no flag change, no busy.
- R13: `rd_data` shows the byte at `rd_addr` combinationally, including the result of a write on the preceding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 program, 1 small erase, 2 medium erase, 3 sector erase, 4 whole erase |
| req_addr | input | ADDR_W (11) | Byte address of the request |
| req_data | input | 8 | Byte to program |
| wel | input | 1 | Current write-enable latch state |
| rd_addr | input | ADDR_W (11) | Read port address |
| rd_data | output | 8 | Byte stored at `rd_addr` |
| busy | output | 1 | Erase sweep in progress |
| err_prot | output | 1 | Sticky: request made while writes were disabled |
| err_size | output | 1 | Sticky: erase size not supported by the part |
| err_zero | output | 1 | Sticky: program tried to set a 0 bit to 1 |

## Verification
Two instances with opposite capability and rewrite settings receive the same requests. The bench programs the same byte twice with overlapping bit patterns. This separates AND-programming from overwrite, and a 1-over-0 pattern separates a raised `err_zero` from a quiet one. Each erase size is aimed at an unaligned address with marker bytes just outside the region, so misalignment or a wrong length shows as a changed marker and a wrong busy count. Requests made with writes disabled, made during a sweep, or carrying reserved op codes are followed by read-back of the bytes they could have touched.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [2:0] {
    FA_PROG        = 3'd0,
    FA_ERASE_SMALL = 3'd1,
    FA_ERASE_MID   = 3'd2,
    FA_ERASE_SECT  = 3'd3,
    FA_ERASE_ALL   = 3'd4
  } fa_op_e;

  localparam logic [7:0] FA_BLANK = 8'hFF;

  function automatic logic fa_is_erase(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd4);
  endfunction
endpackage

// File: rtl/fa_decode.sv
module fa_decode
  import fa_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SMALL_BYTES  = 32,
  parameter int MID_BYTES    = 128,
  parameter int SECT_BYTES   = 256,
  parameter int ARRAY_BYTES  = 2048,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  parameter bit REWRITE_ONES = 1'b0
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wel,
  input  logic              busy,
  input  logic [7:0]        old_byte,
  output logic              prog_we,
  output logic [7:0]        prog_byte,
  output logic              erase_go,
  output logic [ADDR_W-1:0] erase_base,
  output logic [ADDR_W-1:0] erase_last,
  output logic              set_prot,
  output logic              set_size,
  output logic              set_zero
);
  localparam logic [ADDR_W-1:0] SMALL_M1 = ADDR_W'(SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] MID_M1   = ADDR_W'(MID_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECT_M1  = ADDR_W'(SECT_BYTES - 1);
  localparam logic [ADDR_W-1:0] ARRAY_M1 = ADDR_W'(ARRAY_BYTES - 1);

  logic accept, prog_hit, erase_hit, cap_ok;
  logic [ADDR_W-1:0] len_m1;

  always_comb begin
    len_m1 = '0;
    cap_ok = 1'b1;
    case (fa_op_e'(req_op))
      FA_ERASE_SMALL: begin len_m1 = SMALL_M1; cap_ok = CAP_SMALL; end
      FA_ERASE_MID:   begin len_m1 = MID_M1;   cap_ok = CAP_MID;   end
      FA_ERASE_SECT:  len_m1 = SECT_M1;
      FA_ERASE_ALL:   len_m1 = ARRAY_M1;
      default:        len_m1 = '0;
    endcase
  end

  assign accept     = req_valid & ~busy;
  assign prog_hit   = accept & (req_op == FA_PROG);
  assign erase_hit  = accept & fa_is_erase(req_op);
  assign prog_we    = prog_hit;
  assign erase_go   = erase_hit & wel;
  assign erase_base = req_addr & ~len_m1;
  assign erase_last = len_m1;
  assign set_prot   = (prog_hit | erase_hit) & ~wel;
  assign set_size   = erase_hit & ~cap_ok;
  assign set_zero   = prog_hit & (|(req_data & ~old_byte));

  generate
    if (REWRITE_ONES) begin : g_overwrite
      assign prog_byte = req_data;
    end else begin : g_and_in
      assign prog_byte = req_data & old_byte;
    end
  endgenerate
endmodule

// File: rtl/fa_sweep.sv
module fa_sweep #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_go,
  input  logic [ADDR_W-1:0] erase_base,
  input  logic [ADDR_W-1:0] erase_last,
  output logic              busy,
  output logic              sw_we,
  output logic [ADDR_W-1:0] sw_addr
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cur_q, cur_d, left_q, left_d;
  logic              step_en;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    left_d = left_q;
    if (busy_q) begin
      if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cur_d  = cur_q + 1'b1;
        left_d = left_q - 1'b1;
      end
    end else if (erase_go) begin
      busy_d = 1'b1;
      cur_d  = erase_base;
      left_d = erase_last;
    end
  end

  assign step_en = busy_q | erase_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      left_q <= left_d;
    end
  end

  assign busy    = busy_q;
  assign sw_we   = busy_q;
  assign sw_addr = cur_q;
endmodule

// File: rtl/fa_store.sv
module fa_store
  import fa_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] ra0,
  output logic [7:0]        rd0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [7:0]        rd1
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= FA_BLANK;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rd0 = cells[ra0];
  assign rd1 = cells[ra1];
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import fa_pkg::*;
#(
  parameter int SECT_BYTES   = 256,
  parameter int SECT_COUNT   = 8,
  parameter int SMALL_BYTES  = 32,
  parameter int MID_BYTES    = 128,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  parameter bit REWRITE_ONES = 1'b0,
  localparam int ARRAY_BYTES = SECT_BYTES * SECT_COUNT,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              err_prot,
  output logic              err_size,
  output logic              err_zero
);
  logic              prog_we, erase_go, sw_we;
  logic              set_prot, set_size, set_zero;
  logic [7:0]        prog_byte, old_byte, wdata;
  logic [ADDR_W-1:0] erase_base, erase_last, sw_addr, waddr;
  logic              we;

  fa_decode #(
    .ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECT_BYTES(SECT_BYTES), .ARRAY_BYTES(ARRAY_BYTES),
    .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID), .REWRITE_ONES(REWRITE_ONES)
  ) u_decode (
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .wel(wel), .busy(busy), .old_byte(old_byte),
    .prog_we(prog_we), .prog_byte(prog_byte), .erase_go(erase_go),
    .erase_base(erase_base), .erase_last(erase_last),
    .set_prot(set_prot), .set_size(set_size), .set_zero(set_zero)
  );

  fa_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go),
    .erase_base(erase_base), .erase_last(erase_last),
    .busy(busy), .sw_we(sw_we), .sw_addr(sw_addr)
  );

  // Programs are accepted only when idle, so the two writers never collide.
  assign we    = sw_we | prog_we;
  assign waddr = sw_we ? sw_addr : req_addr;
  assign wdata = sw_we ? FA_BLANK : prog_byte;

  fa_store #(.ADDR_W(ADDR_W), .DEPTH(ARRAY_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .ra0(rd_addr), .rd0(rd_data), .ra1(req_addr), .rd1(old_byte)
  );

  logic prot_q, size_q, zero_q;
  logic prot_d, size_d, zero_d, flag_en;

  always_comb begin
    prot_d  = prot_q | set_prot;
    size_d  = size_q | set_size;
    zero_d  = zero_q | set_zero;
    flag_en = set_prot | set_size | set_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      size_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (flag_en) begin
      prot_q <= prot_d;
      size_q <= size_d;
      zero_q <= zero_d;
    end
  end

  assign err_prot = prot_q;
  assign err_size = size_q;
  assign err_zero = zero_q;
endmodule

// File: rtl/fa_engine_checks.sv
module fa_engine_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       wel,
  input logic       busy,
  input logic       err_prot,
  input logic       err_size,
  input logic       err_zero
);
  logic idle_req, erase_req;
  assign idle_req  = req_valid && !busy;
  assign erase_req = idle_req && (req_op >= 3'd1) && (req_op <= 3'd4);

  p_erase_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && wel) |=> busy);

  p_erase_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !wel) |=> (!busy && err_prot));

  p_prog_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && req_op == 3'd0 && !wel) |=> err_prot);

  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({err_prot, err_size, err_zero}));

  p_reserved_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && req_op > 3'd4) |=> (!busy && $stable({err_prot, err_size, err_zero})));

  p_sticky_prot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_prot |=> err_prot);

  p_sticky_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_size |=> err_size);

  p_sticky_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |=> err_zero);
endmodule

bind flash_pe_engine fa_engine_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .wel(wel), .busy(busy), .err_prot(err_prot), .err_size(err_size),
  .err_zero(err_zero)
);

// File: tb/flash_pe_engine_test.sv
`timescale 1ns/1ps
module flash_pe_engine_test;
  localparam int ARR = 2048;
  localparam int AW  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic wel = 1'b0;
  logic [AW-1:0] rd_addr = '0;

  logic [7:0] rd0, rd1;
  logic busy0, busy1, ep0, ep1, es0, es1, ez0, ez1;

  always #4 clk = ~clk;

  flash_pe_engine #(.CAP_SMALL(1'b1), .CAP_MID(1'b0), .REWRITE_ONES(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wel(wel), .rd_addr(rd_addr),
    .rd_data(rd0), .busy(busy0), .err_prot(ep0), .err_size(es0), .err_zero(ez0));

  flash_pe_engine #(.CAP_SMALL(1'b0), .CAP_MID(1'b1), .REWRITE_ONES(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wel(wel), .rd_addr(rd_addr),
    .rd_data(rd1), .busy(busy1), .err_prot(ep1), .err_size(es1), .err_zero(ez1));

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mm [2][ARR];
  int  mbusy [2];
  int  mcur  [2];
  bit  mp [2], ms [2], mz [2];
  bit  cap_s [2] = '{1'b1, 1'b0};
  bit  cap_m [2] = '{1'b0, 1'b1};
  bit  rw    [2] = '{1'b0, 1'b1};

  function automatic int region_len(input int op);
    case (op)
      1: return 32;
      2: return 128;
      3: return 256;
      4: return ARR;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input int k);
    int a, op, len;
    logic [7:0] old;
    a  = int'(req_addr);
    op = int'(req_op);
    if (mbusy[k] > 0) begin
      mm[k][mcur[k]] = 8'hFF;
      mcur[k]++;
      mbusy[k]--;
    end else if (req_valid) begin
      if (op == 0) begin
        old = mm[k][a];
        if ((req_data & ~old) != 8'h00) mz[k] = 1'b1;
        if (!wel) mp[k] = 1'b1;
        mm[k][a] = rw[k] ? req_data : (old & req_data);
      end else if (op <= 4) begin
        len = region_len(op);
        if ((op == 1 && !cap_s[k]) || (op == 2 && !cap_m[k])) ms[k] = 1'b1;
        if (!wel) mp[k] = 1'b1;
        else begin
          mcur[k]  = a - (a % len);
          mbusy[k] = len;
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < ARR; i++) mm[k][i] = 8'hFF;
        mbusy[k] = 0; mcur[k] = 0; mp[k] = 0; ms[k] = 0; mz[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) model_step(k);
    end
  end

  // Lockstep comparison, away from the active edge.
  always @(negedge clk) begin
    chk("R13 lockstep rd_data uut", rd0, mm[0][rd_addr]);
    chk("R13 lockstep rd_data uut_alt", rd1, mm[1][rd_addr]);
    chk("R5 lockstep busy uut", busy0, mbusy[0] > 0);
    chk("R5 lockstep busy uut_alt", busy1, mbusy[1] > 0);
    chk("R8 lockstep err_prot", {ep0, ep1}, {mp[0], mp[1]});
    chk("R9 lockstep err_size", {es0, es1}, {ms[0], ms[1]});
    chk("R10 lockstep err_zero", {ez0, ez1}, {mz[0], mz[1]});
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R5 watchdog: actual=%0d expected<%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input int op, input int a, input int d, input bit w);
    @(negedge clk); #1;
    req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(a); req_data = 8'(d); wel = w;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] v0, output logic [7:0] v1);
    @(negedge clk); #1;
    rd_addr = AW'(a);
    #2;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic count_busy(output int n0);
    n0 = 0;
    while (busy0 && n0 < 5000) begin
      n0++;
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((busy0 || busy1) && g < 5000) begin
      g++;
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  logic [7:0] v0, v1;
  int n;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(0, v0, v1);    chk("R1 byte 0 after reset", v0, 8'hFF);
    peek(2047, v0, v1); chk("R1 byte 2047 after reset", v1, 8'hFF);
    chk("R1 busy after reset", busy0, 0);
    chk("R1 flags after reset", {ep0, es0, ez0}, 3'b000);

    // R2 / R3 / R10 / R13: two programs with overlapping bits
    issue(0, 5, 8'hA5, 1'b1);
    #2 rd_addr = AW'(5); #1;
    chk("R13 read after program", rd0, 8'hA5);
    chk("R10 no flag for 1->0 only", ez0, 0);
    issue(0, 5, 8'h3C, 1'b1);
    peek(5, v0, v1);
    chk("R2 AND programming", v0, 8'h24);
    chk("R3 overwrite programming", v1, 8'h3C);
    chk("R10 zero-to-one flag uut", ez0, 1);
    chk("R10 zero-to-one flag uut_alt", ez1, 1);

    // R12 reserved op codes
    issue(5, 6, 8'h00, 1'b1);
    issue(7, 6, 8'h00, 1'b1);
    peek(6, v0, v1);
    chk("R12 reserved op leaves byte", v0, 8'hFF);
    chk("R12 reserved op no busy", busy0, 0);
    chk("R12 reserved op no flags", {ep0, es0}, 2'b00);

    // R8 program while protected
    issue(0, 7, 8'h0F, 1'b0);
    peek(7, v0, v1);
    chk("R8 protected program still writes", v0, 8'h0F);
    chk("R8 protected program flag", ep0, 1);
    repeat (3) @(negedge clk);
    chk("R11 flags held", {ep0, ez0}, 2'b11);

    // R11 / R1 reset clears flags and array
    do_reset();
    #1;
    chk("R11 flags cleared by reset", {ep0, es0, ez0, ep1, es1, ez1}, 6'b0);
    peek(5, v0, v1);
    chk("R1 array blank after reset", v0, 8'hFF);

    // R4 / R5 / R9 small erase, unaligned address
    issue(0, 31, 8'h00, 1'b1);
    issue(0, 40, 8'h00, 1'b1);
    issue(0, 64, 8'h00, 1'b1);
    issue(1, 45, 0, 1'b1);
    count_busy(n);
    chk("R5 small erase busy length", n, 32);
    wait_idle();
    peek(40, v0, v1);
    chk("R4 small erase inside uut", v0, 8'hFF);
    chk("R9 unsupported small erase still runs", v1, 8'hFF);
    peek(31, v0, v1); chk("R4 small erase below region", v0, 8'h00);
    peek(64, v0, v1); chk("R4 small erase above region", v0, 8'h00);
    chk("R9 supported size no flag", es0, 0);
    chk("R9 unsupported size flag", es1, 1);

    // R6 request during a medium erase is ignored
    issue(0, 130, 8'h00, 1'b1);
    issue(2, 200, 0, 1'b1);
    issue(0, 1000, 8'h00, 1'b0);
    chk("R6 busy during medium erase", busy0, 1);
    wait_idle();
    peek(1000, v0, v1);
    chk("R6 program during busy ignored", v0, 8'hFF);
    chk("R6 no prot flag from busy request", ep0, 0);
    peek(130, v0, v1);
    chk("R4 medium erase region", v0, 8'hFF);
    chk("R9 medium erase unsupported flag", es0, 1);

    // R7 protected sector erase dropped
    issue(0, 300, 8'h00, 1'b1);
    issue(0, 512, 8'h11, 1'b1);
    issue(0, 250, 8'h22, 1'b1);
    issue(3, 300, 0, 1'b0);
    chk("R7 protected erase no busy", busy0, 0);
    chk("R7 protected erase flag", ep0, 1);
    peek(300, v0, v1);
    chk("R7 protected erase leaves array", v0, 8'h00);

    // R4 / R5 sector erase
    issue(3, 300, 0, 1'b1);
    count_busy(n);
    chk("R5 sector erase busy length", n, 256);
    wait_idle();
    peek(300, v0, v1); chk("R4 sector erase inside", v0, 8'hFF);
    peek(512, v0, v1); chk("R4 sector erase above", v0, 8'h11);
    peek(250, v0, v1); chk("R4 sector erase below", v0, 8'h22);

    // R4 / R5 whole-array erase
    issue(0, 0, 8'h00, 1'b1);
    issue(0, 2047, 8'h00, 1'b1);
    issue(4, 1234, 0, 1'b1);
    count_busy(n);
    chk("R5 whole erase busy length", n, ARR);
    wait_idle();
    peek(0, v0, v1);    chk("R4 whole erase first byte", v0, 8'hFF);
    peek(2047, v0, v1); chk("R4 whole erase last byte", v1, 8'hFF);
    peek(512, v0, v1);  chk("R4 whole erase middle", v0, 8'hFF);

    // R3 rewrite-ones restores ones, AND mode cannot
    do_reset();
    issue(0, 9, 8'h00, 1'b1);
    issue(0, 9, 8'hFF, 1'b1);
    peek(9, v0, v1);
    chk("R2 AND mode keeps zeros", v0, 8'h00);
    chk("R3 rewrite mode restores ones", v1, 8'hFF);
    chk("R10 flag also in rewrite mode", ez1, 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule